// File: doc/BRIEF.md
# Register-File Return Stack Controller

This block runs an eight-level return stack whose storage is a slice of a 64-byte general-purpose register memory. On a push it saves a 12-bit return address together with four status flags; on a pop it brings them back, or brings back only the address and leaves the flags as they were. A 3-bit pointer names the next free level. It is published on `sp_o` so that it can sit in the low bits of a status word.

Each level takes two bytes at fixed addresses. The low byte holds return-address bits 7..0. The high byte carries the flags in its upper nibble and address bits 11..8 in its lower nibble. The block reaches the register memory through a plain byte-wide port with enable, write enable, address and data. The memory answers a read one clock after the read request. Requests are single-cycle strobes, not streams, so the block has no back-pressure handshake. Strobes that arrive while an operation is running are dropped, and software is expected to wait for `done_o` before the next one.

Top module: `rstk_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sp_o`, `pc_o`, `flags_o` and `done_o` are all zero and `mem_en_o` is low until a request is accepted.
- R2: A push writes `pc_i[7:0]` to byte address 8+2·sp in its first access cycle. In the next cycle it writes {`flags_i[3:0]`, `pc_i[11:8]`} to address 9+2·sp, with the flags in bits 7..4.
- R3: The pointer of a push rises by one only after both of its bytes are written; during the writes the old pointer selects the level.
- R4: A full pop (`pop_full_i`) lowers the pointer on the accepting edge. It then reads the low and the high byte of the level the new pointer names. `pc_o` becomes {high[3:0], low} and `flags_o` becomes high[7:4].
- R5: An address-only pop (`pop_pc_i`) restores `pc_o` exactly as R4 does and leaves `flags_o` unchanged.
- R6: The pointer wraps modulo 8: a push at pointer 7 gives 0, and a pop at pointer 0 gives 7 and reads the bytes at addresses 16h/17h. No error is signalled.
- R7: The edge that accepts a request is followed by two access cycles and one finishing cycle. `done_o` is then high for exactly one cycle, and restored values are visible in that same cycle.
- R8: Strobes that arrive while an operation is in progress are ignored: they start nothing, produce no extra `done_o` and do not move the pointer.
- R9: When strobes coincide in idle, push wins over full pop, and full pop wins over address-only pop.
- R10: The memory port is enabled only in the two access cycles of an operation, and only at addresses 08h..17h. Writes happen only for pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request strobe |
| pop_full_i | input | 1 | Pop that restores address and flags |
| pop_pc_i | input | 1 | Pop that restores the address only |
| pc_i | input | 12 | Return address to save |
| flags_i | input | 4 | Flags to save, bit 3 down to bit 0 |
| pc_o | output | 12 | Restored return address |
| flags_o | output | 4 | Restored flags |
| sp_o | output | 3 | Stack pointer (next free level) |
| done_o | output | 1 | One-cycle completion pulse |
| mem_en_o | output | 1 | Register-memory access enable |
| mem_we_o | output | 1 | Register-memory write enable |
| mem_addr_o | output | 6 | Register-memory byte address |
| mem_wdata_o | output | 8 | Register-memory write data |
| mem_rdata_i | input | 8 | Register-memory read data, one cycle after the request |

## Verification
The assertions are checked on every cycle. They cover the single-cycle width of `done_o`, the pointer moving by exactly one in the right direction at the right moment, the parity of the low and high accesses, the address window of every access, and the flags holding still across an address-only pop. The byte layout in memory, the values restored after a mix of pushes and pops, and wrap-around in both directions can only be shown by the bench's sequences. The same holds for dropped strobes and for the choice between coinciding strobes, since each needs a history of operations and a model of the memory contents.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC1 = 2'd1,
    ST_ACC2 = 2'd2,
    ST_FIN  = 2'd3
  } rstk_state_e;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POPF = 2'd1,
    OP_POPA = 2'd2
  } rstk_op_e;
endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr #(
  parameter int SP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            dec,
  output logic [SP_W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= '0;
    else if (inc) sp <= sp + 1'b1;
    else if (dec) sp <= sp - 1'b1;
  end

  // R3 R6
  ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> sp == SP_W'($past(sp) + 1'b1));
  // R4 R6
  ptr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> sp == SP_W'($past(sp) - 1'b1));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(sp));
endmodule

// File: rtl/rstk_seq.sv
module rstk_seq
  import rstk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_req,
  input  logic        popf_req,
  input  logic        popa_req,
  output rstk_state_e state,
  output rstk_op_e    op,
  output logic        accept,
  output logic        sp_inc,
  output logic        sp_dec,
  output logic        done
);
  rstk_op_e op_sel;

  assign accept = (state == ST_IDLE) && (push_req || popf_req || popa_req);
  assign op_sel = push_req ? OP_PUSH : (popf_req ? OP_POPF : OP_POPA);
  assign sp_dec = accept && !push_req;
  assign sp_inc = (state == ST_FIN) && (op == OP_PUSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op    <= OP_PUSH;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= ST_ACC1;
          op    <= op_sel;
        end
        ST_ACC1: state <= ST_ACC2;
        ST_ACC2: state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC1) |=> (state == ST_ACC2));
  // R7
  done_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state) == ST_FIN);
endmodule

// File: rtl/rstk_xfer.sv
module rstk_xfer
  import rstk_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int FLAG_W = 4,
  parameter int BYTE_W = 8,
  parameter int SP_W   = 3,
  parameter int ADDR_W = 6,
  parameter int BASE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rstk_state_e       state,
  input  rstk_op_e          op,
  input  logic              accept,
  input  logic [SP_W-1:0]   sp,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [BYTE_W-1:0] rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [PC_W-1:0]   pc_out,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int PCH_W = PC_W - BYTE_W;
  localparam int DEPTH = 1 << SP_W;
  localparam int TOP   = BASE + 2 * DEPTH - 1;

  logic [PC_W-1:0]   pc_q;
  logic [FLAG_W-1:0] fl_q;
  logic [BYTE_W-1:0] lo_q;
  logic              hi_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      fl_q <= '0;
    end else if (accept) begin
      pc_q <= pc_in;
      fl_q <= flags_in;
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    hi_sel    = 1'b0;
    mem_wdata = '0;
    if (state == ST_ACC1) begin
      mem_en    = 1'b1;
      mem_we    = (op == OP_PUSH);
      mem_wdata = pc_q[BYTE_W-1:0];
    end else if (state == ST_ACC2) begin
      mem_en    = 1'b1;
      mem_we    = (op == OP_PUSH);
      hi_sel    = 1'b1;
      mem_wdata = {fl_q, pc_q[PC_W-1:BYTE_W]};
    end
  end

  assign mem_addr = ADDR_W'(BASE) + ADDR_W'({sp, hi_sel});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      pc_out    <= '0;
      flags_out <= '0;
    end else begin
      if (state == ST_ACC2 && op != OP_PUSH) lo_q <= rdata;
      if (state == ST_FIN && op != OP_PUSH) begin
        pc_out <= {rdata[PCH_W-1:0], lo_q};
        if (op == OP_POPF) flags_out <= rdata[BYTE_W-1 -: FLAG_W];
      end
    end
  end

  // R10
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (int'(mem_addr) >= BASE) && (int'(mem_addr) <= TOP));
  // R2
  lo_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && state == ST_ACC1) |-> !mem_addr[0]);
  // R2
  hi_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && state == ST_ACC2) |-> mem_addr[0]);
  // R5
  flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN && op == OP_POPA) |=> $stable(flags_out));
  // R10
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_FIN) |-> !mem_en);
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int FLAG_W = 4,
  parameter int BYTE_W = 8,
  parameter int SP_W   = 3,
  parameter int ADDR_W = 6,
  parameter int BASE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_full_i,
  input  logic              pop_pc_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  rstk_state_e state;
  rstk_op_e    op;
  logic        accept, sp_inc, sp_dec;

  rstk_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_i), .popf_req(pop_full_i), .popa_req(pop_pc_i),
    .state(state), .op(op), .accept(accept),
    .sp_inc(sp_inc), .sp_dec(sp_dec), .done(done_o)
  );

  rstk_ptr #(.SP_W(SP_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec), .sp(sp_o)
  );

  rstk_xfer #(
    .PC_W(PC_W), .FLAG_W(FLAG_W), .BYTE_W(BYTE_W),
    .SP_W(SP_W), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n), .state(state), .op(op), .accept(accept),
    .sp(sp_o), .pc_in(pc_i), .flags_in(flags_i), .rdata(mem_rdata_i),
    .mem_en(mem_en_o), .mem_we(mem_we_o), .mem_addr(mem_addr_o),
    .mem_wdata(mem_wdata_o), .pc_out(pc_o), .flags_out(flags_o)
  );

  // R10
  write_push_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (op == OP_PUSH) && mem_en_o);
  // R3
  push_ptr_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_addr_o[0]) |=> $stable(sp_o));
endmodule

// File: tb/rstk_ctrl_tb.sv
module rstk_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_full_i = 1'b0, pop_pc_i = 1'b0;
  logic [11:0] pc_i = '0;
  logic [3:0]  flags_i = '0;
  logic [11:0] pc_o;
  logic [3:0]  flags_o;
  logic [2:0]  sp_o;
  logic        done_o, mem_en_o, mem_we_o;
  logic [5:0]  mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic [7:0]  regmem [64];

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) regmem[mem_addr_o] <= mem_wdata_o;
      mem_rdata_i <= regmem[mem_addr_o];
    end
  end

  rstk_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_full_i(pop_full_i),
    .pop_pc_i(pop_pc_i), .pc_i(pc_i), .flags_i(flags_i), .pc_o(pc_o),
    .flags_o(flags_o), .sp_o(sp_o), .done_o(done_o), .mem_en_o(mem_en_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 push, 1 full pop, 2 address-only pop
    logic [11:0] pc;
    logic [3:0]  fl;
    logic [11:0] epc;
    logic [3:0]  efl;
    logic [2:0]  esp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 12'h123, 4'hA, 12'h000, 4'h0, 3'd1},
    '{2'd0, 12'h456, 4'h5, 12'h000, 4'h0, 3'd2},
    '{2'd0, 12'hABC, 4'hF, 12'h000, 4'h0, 3'd3},
    '{2'd1, 12'h000, 4'h0, 12'hABC, 4'hF, 3'd2},
    '{2'd2, 12'h000, 4'h0, 12'h456, 4'hF, 3'd1},
    '{2'd0, 12'h7E1, 4'h3, 12'h456, 4'hF, 3'd2},
    '{2'd1, 12'h000, 4'h0, 12'h7E1, 4'h3, 3'd1},
    '{2'd1, 12'h000, 4'h0, 12'h123, 4'hA, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic ps, input logic pf, input logic pa,
                       input logic [11:0] pc, input logic [3:0] fl, output int lat);
    @(negedge clk);
    push_i = ps; pop_full_i = pf; pop_pc_i = pa; pc_i = pc; flags_i = fl;
    @(negedge clk);
    push_i = 1'b0; pop_full_i = 1'b0; pop_pc_i = 1'b0;
    lat = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      lat++;
      if (done_o) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", 32'(sp_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 pc", 32'(pc_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem quiet", 32'(mem_en_o), 0);
    chk("R1 flags", 32'(flags_o), 0);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VEC[i];
      do_op(v.op == 2'd0, v.op == 2'd1, v.op == 2'd2, v.pc, v.fl, lat);
      chk("R7 latency", 32'(lat), 3);
      chk("R4 R5 pc", 32'(pc_o), 32'(v.epc));
      chk("R4 R5 flags", 32'(flags_o), 32'(v.efl));
      chk("R3 R4 sp", 32'(sp_o), 32'(v.esp));
      if (v.op == 2'd0) begin
        chk("R2 low byte", 32'(regmem[8 + 2*(int'(v.esp) - 1)]), 32'(v.pc[7:0]));
        chk("R2 high byte", 32'(regmem[9 + 2*(int'(v.esp) - 1)]), 32'({v.fl, v.pc[11:8]}));
      end
      @(negedge clk);
      chk("R7 single pulse", 32'(done_o), 0);
    end

    // R6 wrap on push
    for (int i = 0; i < 8; i++) begin
      do_op(1'b1, 1'b0, 1'b0, 12'(i * 273), 4'(i), lat);
    end
    chk("R6 push wrap sp", 32'(sp_o), 0);
    do_op(1'b1, 1'b0, 1'b0, 12'hF0F, 4'h6, lat);
    chk("R6 overwrite low", 32'(regmem[8]), 32'h0F);
    chk("R6 overwrite high", 32'(regmem[9]), 32'h6F);
    chk("R6 sp one", 32'(sp_o), 1);
    do_op(1'b0, 1'b1, 1'b0, 12'h0, 4'h0, lat);
    chk("R4 pop level0 pc", 32'(pc_o), 32'hF0F);
    chk("R4 pop level0 flags", 32'(flags_o), 6);
    // R6 underflow reads level 7 (16h/17h)
    do_op(1'b0, 1'b1, 1'b0, 12'h0, 4'h0, lat);
    chk("R6 underflow sp", 32'(sp_o), 7);
    chk("R6 underflow pc", 32'(pc_o), 32'h777);
    chk("R6 underflow flags", 32'(flags_o), 7);

    // R9 push beats pop
    do_op(1'b1, 1'b1, 1'b1, 12'h2A5, 4'h9, lat);
    chk("R9 push wins sp", 32'(sp_o), 0);
    chk("R9 flags untouched", 32'(flags_o), 7);
    chk("R9 low byte 16h", 32'(regmem[22]), 32'hA5);
    chk("R9 high byte 17h", 32'(regmem[23]), 32'h92);

    // R5 address-only pop keeps flags
    do_op(1'b0, 1'b0, 1'b1, 12'h0, 4'h0, lat);
    chk("R5 pc", 32'(pc_o), 32'h2A5);
    chk("R5 flags kept", 32'(flags_o), 7);
    chk("R9 pop sp", 32'(sp_o), 7);

    // R8 strobe during busy ignored
    @(negedge clk);
    push_i = 1'b1; pc_i = 12'h3C3; flags_i = 4'h1;
    @(negedge clk);
    push_i = 1'b0; pop_full_i = 1'b1;
    @(negedge clk);
    pop_full_i = 1'b0;
    lat = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done_o) lat++;
    end
    chk("R8 one done only", 32'(lat), 1);
    chk("R8 sp", 32'(sp_o), 0);
    chk("R8 flags", 32'(flags_o), 7);

    // R1 reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset sp", 32'(sp_o), 0);
    chk("R1 reset pc", 32'(pc_o), 0);
    chk("R1 reset flags", 32'(flags_o), 0);
    chk("R1 reset mem", 32'(mem_en_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule